// File: doc/BRIEF.md
# Serial Boot Loader Sequencer

This block fills a word-addressed program memory from a byte-wide serial receive stream and then releases a processor. Each accepted byte is also sent back on a byte-wide transmit interface, so a host can confirm what arrived. Bytes are grouped into 24-bit words. The least significant byte of each word comes first.

The first word received gives the number of program words to follow. The second word gives the start address. The payload words that follow are stored at the start address and at the addresses after it. Once the final word has been written, the block emits a one-cycle start pulse that carries the start address. In the same cycle it requests that the processor's operating mode be cleared and its condition flags be cleared. It then refuses all further input until reset.

The transmit side can stall. In that case the echo waits in a one-byte holding register, and the receive side is throttled until that byte has left.

Top module: `boot_loader_seq`

## Requirements
- R1: Every accepted byte, header bytes included, appears on the transmit interface in arrival order. While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R2: While an echo byte is waiting and `tx_ready` is low, `rx_ready` is low.
- R3: The first three accepted bytes form the program size and the next three form the start address. In both, the first byte fills bits 7:0, the second bits 15:8 and the third bits 23:16. Only bits ADDR_W-1:0 of the address word are used.
- R4: Payload bytes are packed the same way. Payload byte 3k+j fills bits 8j+7:8j of word k.
- R5: Word k is written with a one-cycle `mem_we` at address (start + k) mod 2^ADDR_W. Exactly size writes occur.
- R6: After the cycle that carries the final write, `go` pulses for exactly one cycle, never in the same cycle as that write. During the pulse `go_addr` equals the start address, and `clr_mode` and `clr_flags` are high.
- R7: A program size of zero produces no memory write, and `go` follows the address word.
- R8: After `go`, `rx_ready` stays low and nothing more is echoed until reset.
- R9: A synchronous active-low reset clears `tx_valid`, `mem_we` and `go`. The block then waits for the size word with `rx_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive byte available |
| rx_data | input | BYTE_W | Receive byte |
| rx_ready | output | 1 | Block accepts the receive byte |
| tx_valid | output | 1 | Echo byte available |
| tx_data | output | BYTE_W | Echo byte |
| tx_ready | input | 1 | Transmit side takes the echo byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | WORD_W | Memory write data |
| go | output | 1 | One-cycle start pulse |
| go_addr | output | ADDR_W | Start address for execution |
| clr_mode | output | 1 | Operating-mode clear request |
| clr_flags | output | 1 | Condition-flag clear request |

## Verification
The assertions check these properties on every cycle:
- a stalled echo holds its value;
- no byte is taken while an echo is pending;
- write strobes are isolated pulses issued only during loading;
- the byte index stays in range;
- `go` is single, and input is locked out after it.

Only the bench scenarios can show the correct values:
- the byte order inside words;
- the address sequence, including wrap at the top of memory;
- the exact write count, including the zero-size case;
- that every echoed byte matches what was sent.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [2:0] {
    PH_SIZE,
    PH_ADDR,
    PH_LOAD,
    PH_GO,
    PH_DONE
  } phase_t;
endpackage

// File: rtl/boot_echo_buf.sv
module boot_echo_buf #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              can_take,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready
);
  logic              full;
  logic [BYTE_W-1:0] hold;
  logic              drain;

  assign drain    = full && tx_ready;
  assign can_take = !full || tx_ready;
  assign tx_valid = full;
  assign tx_data  = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (in_fire) begin
      full <= 1'b1;
      hold <= in_byte;
    end else if (drain) begin
      full <= 1'b0;
    end
  end

  AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R1
  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !tx_ready) |-> !in_fire); // R2
endmodule

// File: rtl/boot_word_asm.sv
module boot_word_asm #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_fire,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_done,
  output logic [WORD_W-1:0] word_out
);
  localparam int BPW   = WORD_W / BYTE_W;
  localparam int IDX_W = (BPW > 1) ? $clog2(BPW) : 1;

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] acc;
  logic              last_byte;

  function automatic logic [WORD_W-1:0] place_byte(
    input logic [WORD_W-1:0] w,
    input int                pos,
    input logic [BYTE_W-1:0] b
  );
    logic [WORD_W-1:0] r;
    r = w;
    r[pos*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction

  assign last_byte = (idx == IDX_W'(BPW - 1));
  assign word_done = byte_fire && last_byte;
  assign word_out  = place_byte(acc, int'(idx), byte_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      acc <= '0;
    end else if (byte_fire) begin
      acc <= word_out;
      idx <= last_byte ? '0 : idx + 1'b1;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < BPW); // R4
endmodule

// File: rtl/boot_loader_seq.sv
module boot_loader_seq
  import boot_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 24,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              go,
  output logic [ADDR_W-1:0] go_addr,
  output logic              clr_mode,
  output logic              clr_flags
);
  phase_t            phase;
  logic [WORD_W-1:0] size_q;
  logic [WORD_W-1:0] left_q;
  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] wr_q;
  logic              go_q;
  logic              can_take;
  logic              accepting;
  logic              in_fire;
  logic              word_done;
  logic [WORD_W-1:0] word;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  assign accepting = (phase == PH_SIZE) || (phase == PH_ADDR) || (phase == PH_LOAD);
  assign rx_ready  = accepting && can_take;
  assign in_fire   = rx_valid && rx_ready;

  boot_echo_buf #(.BYTE_W(BYTE_W)) u_echo (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_fire  (in_fire),
    .in_byte  (rx_data),
    .can_take (can_take),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready)
  );

  boot_word_asm #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_fire (in_fire),
    .byte_in   (rx_data),
    .word_done (word_done),
    .word_out  (word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_SIZE;
      size_q    <= '0;
      left_q    <= '0;
      start_q   <= '0;
      wr_q      <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      go_q      <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      go_q   <= 1'b0;
      case (phase)
        PH_SIZE: if (word_done) begin
          size_q <= word;
          phase  <= PH_ADDR;
        end
        PH_ADDR: if (word_done) begin
          start_q <= word[ADDR_W-1:0];
          wr_q    <= word[ADDR_W-1:0];
          left_q  <= size_q;
          phase   <= (size_q == '0) ? PH_GO : PH_LOAD;
        end
        PH_LOAD: if (word_done) begin
          mem_we    <= 1'b1;
          mem_addr  <= wr_q;
          mem_wdata <= word;
          wr_q      <= next_addr(wr_q);
          left_q    <= left_q - 1'b1;
          if (left_q == WORD_W'(1)) phase <= PH_GO;
        end
        PH_GO: begin
          go_q  <= 1'b1;
          phase <= PH_DONE;
        end
        default: ;
      endcase
    end
  end

  assign go        = go_q;
  assign go_addr   = start_q;
  assign clr_mode  = go_q;
  assign clr_flags = go_q;

  AST_WRITE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R5
  AST_WRITE_ONLY_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == PH_LOAD || phase == PH_GO)); // R5
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go); // R6
  AST_GO_NOT_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !mem_we); // R6
  AST_LOCKED_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !rx_ready); // R8
  AST_LOAD_HAS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD) |-> (left_q != '0)); // R7
endmodule

// File: tb/boot_loader_seq_tb.sv
module boot_loader_seq_tb;
  localparam int BW = 8;
  localparam int WW = 24;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [BW-1:0] rx_data = '0;
  logic          rx_ready;
  logic          tx_valid;
  logic [BW-1:0] tx_data;
  logic          tx_ready = 1'b1;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata;
  logic          go;
  logic [AW-1:0] go_addr;
  logic          clr_mode;
  logic          clr_flags;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int mode   = 0;

  logic [7:0] sent[$];
  logic [7:0] echoed[$];
  logic [7:0] payload[$];
  int          n_wr;
  int          last_wr_cyc;
  int          go_cnt;
  int          exp_size;
  logic [AW-1:0] exp_start;
  logic        pend;
  logic [7:0]  pend_data;

  always #10 clk = ~clk;

  boot_loader_seq #(.BYTE_W(BW), .WORD_W(WW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .go(go), .go_addr(go_addr),
    .clr_mode(clr_mode), .clr_flags(clr_flags)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(posedge clk);
    #1;
    case (mode)
      0:       tx_ready = 1'b1;
      1:       tx_ready = (cyc % 3) != 0;
      default: tx_ready = (cyc % 5) < 2;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) chk(tx_valid && tx_data == pend_data, "R1 hold", {23'd0, tx_valid, tx_data}, {24'd1, pend_data});
      pend = tx_valid && !tx_ready;
      pend_data = tx_data;
      if (tx_valid && tx_ready) echoed.push_back(tx_data);
      if (tx_valid && !tx_ready) chk(rx_ready == 1'b0, "R2", 32'(rx_ready), 32'd0);
      if (mem_we) begin
        if (n_wr < exp_size) begin
          logic [AW-1:0] ea;
          logic [WW-1:0] ed;
          ea = exp_start + AW'(n_wr);
          ed = {payload[3*n_wr+2], payload[3*n_wr+1], payload[3*n_wr]};
          chk(mem_addr == ea, "R5 addr", 32'(mem_addr), 32'(ea));
          chk(mem_wdata == ed, "R4 data", 32'(mem_wdata), 32'(ed));
        end else begin
          chk(1'b0, "R5 extra write", 32'(n_wr), 32'(exp_size));
        end
        n_wr++;
        last_wr_cyc = cyc;
      end
      if (go) begin
        go_cnt++;
        chk(go_addr == exp_start, "R6 go_addr", 32'(go_addr), 32'(exp_start));
        chk(clr_mode && clr_flags, "R6 clears", {30'd0, clr_mode, clr_flags}, 32'd3);
        chk(n_wr == exp_size, "R5 count at go", 32'(n_wr), 32'(exp_size));
        if (exp_size > 0) chk(cyc > last_wr_cyc, "R6 after write", 32'(cyc), 32'(last_wr_cyc + 1));
      end
    end else begin
      pend = 1'b0;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!tx_valid && !mem_we && !go, "R9 reset outputs", {29'd0, tx_valid, mem_we, go}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready == 1'b1, "R9 ready after reset", 32'(rx_ready), 32'd1);
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    sent.push_back(b);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic run(input int size, input logic [AW-1:0] start, input logic [7:0] hi, input int m, input int tag);
    logic [WW-1:0] aw;
    mode = m;
    do_reset();
    sent.delete(); echoed.delete(); payload.delete();
    n_wr = 0; last_wr_cyc = 0; go_cnt = 0;
    exp_size = size; exp_start = start;
    for (int i = 0; i < 3 * size; i++) payload.push_back(8'((tag * 29 + i * 13 + 5) & 255));
    aw = {hi, start};
    for (int j = 0; j < 3; j++) send_byte(8'(size >> (8 * j)));
    for (int j = 0; j < 3; j++) send_byte(aw[8*j +: 8]);
    for (int i = 0; i < 3 * size; i++) send_byte(payload[i]);
    repeat (12) @(negedge clk);
    chk(go_cnt == 1, "R6 single go", 32'(go_cnt), 32'd1);
    if (size == 0) chk(n_wr == 0, "R7 no writes", 32'(n_wr), 32'd0);
    else chk(n_wr == size, "R3 size count", 32'(n_wr), 32'(size));
    chk(echoed.size() == sent.size(), "R1 echo count", 32'(echoed.size()), 32'(sent.size()));
    for (int i = 0; i < sent.size() && i < echoed.size(); i++)
      chk(echoed[i] == sent[i], "R1 echo byte", 32'(echoed[i]), 32'(sent[i]));
    rx_valid = 1'b1;
    rx_data = 8'h5A;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rx_ready == 1'b0, "R8 locked", 32'(rx_ready), 32'd0);
    end
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(echoed.size() == sent.size(), "R8 no echo", 32'(echoed.size()), 32'(sent.size()));
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    pend = 1'b0;
    for (int m = 0; m < 3; m++) begin
      run(0, AW'(16'h0040 + m), 8'h00, m, m * 10);
      run(1, AW'(16'h1234), 8'hA5, m, m * 10 + 1);
      run(2, AW'(16'h0100 * m), 8'h3C, m, m * 10 + 2);
      run(4, AW'(16'h7FFE), 8'h00, m, m * 10 + 3);
      run(3, AW'(16'hFFFE), 8'hFF, m, m * 10 + 4);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule